// File: doc/BRIEF.md
# Three-Entry Sequential Code Lock

This block is a synchronous Moore state machine that checks a three-value code entered one value at a time. A new entry is offered on a value bus together with a single-cycle strobe. While the machine waits for an entry it drives a select output that names which of three code inputs the next entry must match. A comparator tests the entry against the selected code.

A correct strobed entry moves the machine one step forward. After three correct entries it reaches an unlocked state. A wrong strobed entry at any step sends it to an error state. The unlocked state and the error state both hold until reset.

The code values are static inputs. Debouncing the keypad, storing or changing the code, and any timeout live outside this block. Both outputs are decoded from the registered state only.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine enters the first checking step. After that edge `code_sel` reads 1 and `unlocked` reads 0.
- R2: The three checking steps drive `code_sel` to 1, 2 and 3, which point at `code_1st`, `code_2nd` and `code_3rd`. In all three steps `unlocked` is 0.
- R3: In a checking step, a strobed entry equal to the selected code advances the machine at the next edge. `code_sel` goes from 1 to 2, or from 2 to 3. From 3 the machine unlocks.
- R4: In a checking step, a strobed entry that differs from the selected code sends the machine to the error state at the next edge. The error state drives `code_sel` = 0 and `unlocked` = 0.
- R5: While `entry_new` is low, the state does not change, whatever value `entry_val` carries.
- R6: The unlocked state drives `unlocked` = 1 and `code_sel` = 0.
- R7: The unlocked state and the error state ignore every strobed entry, right or wrong. Only reset leaves them.
- R8: Reset returns the machine to the first checking step from any state, including the unlocked and error states.
- R9: Only the code named by `code_sel` takes part in the compare. An entry equal to one of the other two codes, but not to the selected one, counts as wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| entry_val | input | DIGIT_W | Value of the entry being offered |
| entry_new | input | 1 | Single-cycle strobe marking a new entry |
| code_1st | input | DIGIT_W | First value of the code |
| code_2nd | input | DIGIT_W | Second value of the code |
| code_3rd | input | DIGIT_W | Third value of the code |
| code_sel | output | 2 | Code slot under compare: 1, 2, 3, or 0 when not checking |
| unlocked | output | 1 | High only in the unlocked state |

## Verification
The condition hardest to reach from the ports is the final step of the code: the machine sits in step three and receives a correct strobe, after two earlier correct strobes and with no wrong strobe in between. Uniform random entries almost never get there, and they rarely test the absorbing states afterwards. The stimulus therefore biases each strobed entry toward the code the bench model expects next. It also often sets two code slots to the same value, and it includes directed runs that strobe a value belonging to a code slot other than the selected one.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

   typedef enum logic [2:0] {
      ST_CHK1 = 3'd0,
      ST_CHK2 = 3'd1,
      ST_CHK3 = 3'd2,
      ST_OPEN = 3'd3,
      ST_ERR  = 3'd4
   } lock_state_t;

   localparam int SEL_W = 2;

   localparam logic [SEL_W-1:0] SEL_NONE = 2'd0;
   localparam logic [SEL_W-1:0] SEL_C1   = 2'd1;
   localparam logic [SEL_W-1:0] SEL_C2   = 2'd2;
   localparam logic [SEL_W-1:0] SEL_C3   = 2'd3;

endpackage

// File: rtl/combo_lock_cmp.sv
module combo_lock_cmp
   import combo_lock_pkg::*;
#(
   parameter int DIGIT_W      = 4,
   parameter bit PARALLEL_CMP = 1'b0
) (
   input  logic [SEL_W-1:0]           sel,
   input  logic [2:0][DIGIT_W-1:0]    codes,
   input  logic [DIGIT_W-1:0]         entry,
   output logic                       hit
);

   localparam int N_SLOTS = 3;

   if (DIGIT_W < 1) begin : g_bad_width
      $error("combo_lock_cmp: DIGIT_W must be at least 1");
   end

   if (PARALLEL_CMP) begin : g_parallel
      logic [N_SLOTS-1:0] slot_eq;
      for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
         assign slot_eq[i] = (codes[i] == entry);
      end
      always_comb begin
         unique case (sel)
            SEL_C1:  hit = slot_eq[0];
            SEL_C2:  hit = slot_eq[1];
            SEL_C3:  hit = slot_eq[2];
            default: hit = 1'b0;
         endcase
      end
   end else begin : g_muxed
      logic [DIGIT_W-1:0] target;
      logic               valid_sel;
      always_comb begin
         valid_sel = 1'b1;
         unique case (sel)
            SEL_C1:  target = codes[0];
            SEL_C2:  target = codes[1];
            SEL_C3:  target = codes[2];
            default: begin
               target    = '0;
               valid_sel = 1'b0;
            end
         endcase
      end
      assign hit = valid_sel && (target == entry);
   end

endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm
   import combo_lock_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        strobe,
   input  logic        hit,
   output lock_state_t state
);

   lock_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_CHK1: if (strobe) nxt = hit ? ST_CHK2 : ST_ERR;
         ST_CHK2: if (strobe) nxt = hit ? ST_CHK3 : ST_ERR;
         ST_CHK3: if (strobe) nxt = hit ? ST_OPEN : ST_ERR;
         ST_OPEN: nxt = ST_OPEN;
         ST_ERR:  nxt = ST_ERR;
         default: nxt = ST_ERR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_CHK1;
      else     state <= nxt;
   end

   assert_reset_entry_R1: assert property (@(posedge clk)
      rst |=> (state == ST_CHK1));

   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(state));

   assert_absorbing_R7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_OPEN || state == ST_ERR) |=> $stable(state));

endmodule

// File: rtl/combo_lock_dec.sv
module combo_lock_dec
   import combo_lock_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  lock_state_t       state,
   output logic [SEL_W-1:0]  sel,
   output logic              open_o
);

   always_comb begin
      sel    = SEL_NONE;
      open_o = 1'b0;
      unique case (state)
         ST_CHK1: sel = SEL_C1;
         ST_CHK2: sel = SEL_C2;
         ST_CHK3: sel = SEL_C3;
         ST_OPEN: open_o = 1'b1;
         default: ;
      endcase
   end

   assert_checking_closed_R2: assert property (@(posedge clk) disable iff (rst)
      (sel != SEL_NONE) |-> !open_o);

endmodule

// File: rtl/combo_lock.sv
module combo_lock
   import combo_lock_pkg::*;
#(
   parameter int DIGIT_W      = 4,
   parameter bit PARALLEL_CMP = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [DIGIT_W-1:0] entry_val,
   input  logic               entry_new,
   input  logic [DIGIT_W-1:0] code_1st,
   input  logic [DIGIT_W-1:0] code_2nd,
   input  logic [DIGIT_W-1:0] code_3rd,
   output logic [1:0]         code_sel,
   output logic               unlocked
);

   if (DIGIT_W < 1 || DIGIT_W > 32) begin : g_bad_width
      $error("combo_lock: DIGIT_W out of range");
   end

   lock_state_t             state;
   logic                    hit;
   logic [2:0][DIGIT_W-1:0] codes;

   assign codes = {code_3rd, code_2nd, code_1st};

   combo_lock_cmp #(
      .DIGIT_W      (DIGIT_W),
      .PARALLEL_CMP (PARALLEL_CMP)
   ) u_cmp (
      .sel   (code_sel),
      .codes (codes),
      .entry (entry_val),
      .hit   (hit)
   );

   combo_lock_fsm u_fsm (
      .clk    (clk),
      .rst    (rst),
      .strobe (entry_new),
      .hit    (hit),
      .state  (state)
   );

   combo_lock_dec u_dec (
      .clk    (clk),
      .rst    (rst),
      .state  (state),
      .sel    (code_sel),
      .open_o (unlocked)
   );

   assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
      (entry_new && hit && (code_sel == SEL_C1 || code_sel == SEL_C2))
      |=> (code_sel == $past(code_sel) + 2'd1));

   assert_final_unlock_R3: assert property (@(posedge clk) disable iff (rst)
      (entry_new && hit && code_sel == SEL_C3) |=> unlocked);

   assert_wrong_entry_R4: assert property (@(posedge clk) disable iff (rst)
      (entry_new && !hit && code_sel != SEL_NONE)
      |=> (code_sel == SEL_NONE && !unlocked));

   assert_open_outputs_R6: assert property (@(posedge clk) disable iff (rst)
      unlocked |-> (code_sel == SEL_NONE));

endmodule

// File: tb/combo_lock_test.sv
module combo_lock_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] entry_val = '0;
   logic       entry_new = 1'b0;
   logic [3:0] code_1st = 4'd1;
   logic [3:0] code_2nd = 4'd2;
   logic [3:0] code_3rd = 4'd3;
   logic [1:0] code_sel;
   logic       unlocked;

   int vectors = 0;
   int misses  = 0;
   int mstate  = 0;   // 0..2 checking steps, 3 unlocked, 4 error

   always #2 clk = ~clk;

   combo_lock #(.DIGIT_W(4)) uut (
      .clk       (clk),
      .rst       (rst),
      .entry_val (entry_val),
      .entry_new (entry_new),
      .code_1st  (code_1st),
      .code_2nd  (code_2nd),
      .code_3rd  (code_3rd),
      .code_sel  (code_sel),
      .unlocked  (unlocked)
   );

   function automatic int model_next(int st, logic r, logic nw, logic [3:0] v,
                                     logic [3:0] a, logic [3:0] b, logic [3:0] c);
      logic [3:0] want;
      if (r) return 0;
      if (st >= 3 || !nw) return st;
      want = (st == 0) ? a : (st == 1) ? b : c;
      return (v == want) ? st + 1 : 4;
   endfunction

   function automatic logic [1:0] model_sel(int st);
      return (st <= 2) ? 2'(st + 1) : 2'd0;
   endfunction

   function automatic logic [3:0] model_want(int st);
      return (st == 0) ? code_1st : (st == 1) ? code_2nd : code_3rd;
   endfunction

   task automatic step(input logic r, input logic nw, input logic [3:0] v, input string req);
      @(negedge clk);
      rst       = r;
      entry_new = nw;
      entry_val = v;
      @(posedge clk);
      mstate = model_next(mstate, r, nw, v, code_1st, code_2nd, code_3rd);
      #1;
      vectors++;
      if (code_sel !== model_sel(mstate) || unlocked !== (mstate == 3)) begin
         misses++;
         $display("FAIL %s: sel=%0d unlocked=%0d expected sel=%0d unlocked=%0d",
                  req, code_sel, unlocked, model_sel(mstate), (mstate == 3));
      end
   endtask

   task automatic enter_code(input string req);
      step(1'b0, 1'b1, code_1st, req);
      step(1'b0, 1'b1, code_2nd, req);
      step(1'b0, 1'b1, code_3rd, req);
   endtask

   initial begin
      #4_000_000;
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));

      // R1 reset state
      step(1'b1, 1'b0, 4'd0, "R1");
      step(1'b0, 1'b0, 4'd0, "R1");

      // R2 / R3 / R6: full correct sequence
      code_1st = 4'd9; code_2nd = 4'd4; code_3rd = 4'd14;
      step(1'b1, 1'b0, 4'd0, "R8");
      step(1'b0, 1'b1, 4'd9, "R2_R3");
      step(1'b0, 1'b1, 4'd4, "R2_R3");
      step(1'b0, 1'b1, 4'd14, "R3_R6");
      // R7: unlocked ignores entries
      step(1'b0, 1'b1, 4'd0, "R7");
      step(1'b0, 1'b1, 4'd9, "R7");
      // R8: reset from unlocked
      step(1'b1, 1'b0, 4'd0, "R8");

      // R4 wrong entry at each step; R7 error absorbs correct entries
      for (int k = 0; k < 3; k++) begin
         step(1'b1, 1'b0, 4'd0, "R8");
         for (int j = 0; j < k; j++) step(1'b0, 1'b1, model_want(mstate), "R3");
         step(1'b0, 1'b1, model_want(mstate) ^ 4'd1, "R4");
         step(1'b0, 1'b1, code_1st, "R7");
         step(1'b0, 1'b1, code_2nd, "R7");
      end

      // R5: no strobe, value on bus ignored (including the correct one)
      step(1'b1, 1'b0, 4'd0, "R8");
      step(1'b0, 1'b0, 4'd3, "R5");
      step(1'b0, 1'b0, code_1st, "R5");
      step(1'b0, 1'b1, code_1st, "R3");
      step(1'b0, 1'b0, 4'd0, "R5");
      step(1'b0, 1'b1, code_2nd, "R3");
      step(1'b0, 1'b0, 4'd1, "R5");

      // R9: entry equal to a non-selected slot is wrong
      code_1st = 4'd5; code_2nd = 4'd7; code_3rd = 4'd11;
      step(1'b1, 1'b0, 4'd0, "R8");
      step(1'b0, 1'b1, 4'd7, "R9");
      step(1'b1, 1'b0, 4'd0, "R8");
      step(1'b0, 1'b1, 4'd5, "R9");
      step(1'b0, 1'b1, 4'd11, "R9");

      // R3: all slots equal, full sequence
      code_1st = 4'd15; code_2nd = 4'd15; code_3rd = 4'd15;
      step(1'b1, 1'b0, 4'd0, "R8");
      enter_code("R3");

      // Random episodes biased toward the expected value
      for (int ep = 0; ep < 400; ep++) begin
         code_1st = 4'($urandom);
         code_2nd = ($urandom % 4 == 0) ? code_1st : 4'($urandom);
         code_3rd = ($urandom % 4 == 0) ? code_2nd : 4'($urandom);
         step(1'b1, 1'b0, 4'd0, "R1_R8");
         for (int c = 0; c < 10; c++) begin
            logic       nw;
            logic [3:0] v;
            nw = ($urandom % 3 != 0);
            v  = ($urandom % 6 != 0) ? model_want(mstate) : 4'($urandom);
            step(($urandom % 50 == 0), nw, v, "R3_R4_R5_R7");
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule